// File: doc/BRIEF.md
# Address-matched memory error injector

The injector sits in the write path of a memory controller, between the check-bit encoder and the memory array. Software programs six address match fields (module within its channel, rank, channel, bank, page and column). Each field holds a compare value and a wildcard flag. Software also programs a flip mask, a section selector, an error type and an enable. When a write access hits every non-wildcard field while the injector is armed, the mask is XORed into the selected check-bit sections, the section parity bits are inverted, or both. This lets error-handling logic and software be tested against known, repeatable faults.

The check word has two sections of equal width: the low section and the high section. Each section has one parity bit. Every access, whether corrupted or not, appears at the outputs one clock after it is presented. A single-shot mode disarms the injector after the first corruption. A repeat mode corrupts every matching write until software clears the enable.

Top module: `mem_err_injector`

## Requirements
- R1: After reset, all six match fields have their wildcard flag set and a compare value of zero (each reads 0x80000000). The mask, section, type and enable registers all read zero.
- R2: Registers use a single write strobe with a combinational read at `reg_addr`. The address map is: 0x0 module, 0x1 rank, 0x2 channel, 0x3 bank, 0x4 page, 0x5 column, 0x6 flip mask, 0x7 section, 0x8 type, 0x9 enable. Each field register holds its compare value in the low bits and the wildcard flag in bit 31. Every register reads back what was written, limited to its width. The enable register reads 1 while armed.
- R3: Corruption requires every non-wildcard field to equal the corresponding access field. A mismatch in any single such field leaves the access unchanged and `out_inj` low.
- R4: A field whose wildcard flag is set matches any value of that access field.
- R5: The section selector uses bit 0 (value 1) for the low section, check bits [SEC_W-1:0], and bit 1 (value 2) for the high section, check bits [2*SEC_W-1:SEC_W]. Value 3 selects both. With the ECC bit (type bit 1) set, the mask is XORed into each selected section, so a mask of 64 flips bit 6 of each selected section. The result appears one clock after the access.
- R6: With the parity bit (type bit 2) set, `out_par[0]` is inverted when the low section is selected and `out_par[1]` when the high section is selected. If the ECC bit is clear, the check bits are unchanged.
- R7: With the repeat bit (type bit 0) clear, the injector disarms after the first corruption. The enable register then reads 0 and later matching writes pass unchanged.
- R8: With the repeat bit set, every matching write is corrupted and the injector stays armed. It disarms once zero is written to the enable register, after which matching writes pass unchanged.
- R9: A type with neither the ECC bit nor the parity bit set corrupts nothing, even while armed and matching. It also leaves the injector armed.
- R10: Read accesses (`acc_write` low) and any access while disarmed pass through unchanged with one clock of latency, and `out_inj` stays low.
- R11: Writing any nonzero value to the enable register arms the injector. A register write to the enable takes priority over a self-clear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| acc_valid | input | 1 | Access present this cycle |
| acc_write | input | 1 | Access is a write |
| acc_mod | input | MOD_W | Module index within its channel |
| acc_rank | input | RANK_W | Rank |
| acc_chan | input | CH_W | Channel |
| acc_bank | input | BANK_W | Bank |
| acc_page | input | PAGE_W | Page |
| acc_col | input | COL_W | Column |
| acc_chk | input | 2*SEC_W | Check bits from the encoder |
| acc_par | input | 2 | Section parity bits from the encoder |
| out_valid | output | 1 | Registered access valid |
| out_chk | output | 2*SEC_W | Check bits, possibly corrupted |
| out_par | output | 2 | Parity bits, possibly corrupted |
| out_inj | output | 1 | This output access was corrupted |

## Verification
A stale or wrong arm state shows up on the first matching write after it goes wrong. A single-shot injector that fails to disarm corrupts a second write. A wrongly cleared repeat injector lets a write through. In either case the enable readback disagrees at once. A faulty field comparator or wildcard flag shows up as a corrupted or clean check word one clock after the offending access. A section or type decode error changes exactly the wrong byte or parity bit in that same cycle, so every fault is visible on the cycle after its cause.

// File: rtl/inj_pkg.sv
package inj_pkg;
  localparam int REG_AW = 4;
  localparam int DW     = 32;
  localparam int NFLD   = 6;
  localparam int NSEC   = 2;

  localparam logic [REG_AW-1:0] A_MASK = 4'h6;
  localparam logic [REG_AW-1:0] A_SECT = 4'h7;
  localparam logic [REG_AW-1:0] A_TYPE = 4'h8;
  localparam logic [REG_AW-1:0] A_EN   = 4'h9;

  localparam int T_REPEAT = 0;
  localparam int T_ECC    = 1;
  localparam int T_PAR    = 2;

  function automatic int fw_max(int a, int b, int c, int d, int e, int f);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    if (e > m) m = e;
    if (f > m) m = f;
    return m;
  endfunction

  function automatic logic [DW-1:0] low_ones(int w);
    if (w >= DW) return '1;
    return (DW'(1) << w) - DW'(1);
  endfunction
endpackage

// File: rtl/inj_regs.sv
module inj_regs
  import inj_pkg::*;
#(
  parameter int MOD_W  = 2,
  parameter int RANK_W = 2,
  parameter int CH_W   = 2,
  parameter int BANK_W = 3,
  parameter int PAGE_W = 16,
  parameter int COL_W  = 10,
  parameter int SEC_W  = 8,
  parameter int FW_MAX = fw_max(MOD_W, RANK_W, CH_W, BANK_W, PAGE_W, COL_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [REG_AW-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  input  logic              fire,
  output logic [FW_MAX-1:0] fld_val [NFLD],
  output logic [NFLD-1:0]   fld_any,
  output logic [SEC_W-1:0]  mask,
  output logic [1:0]        section,
  output logic [2:0]        typ,
  output logic              armed
);
  localparam int FW [NFLD] = '{MOD_W, RANK_W, CH_W, BANK_W, PAGE_W, COL_W};

  logic [FW_MAX-1:0] fld_d [NFLD];
  logic [NFLD-1:0]   any_d;
  logic [SEC_W-1:0]  mask_d;
  logic [1:0]        sect_d;
  logic [2:0]        typ_d;
  logic              armed_d;
  logic              en_wr;

  assign en_wr = wr && (addr == A_EN);

  // next state
  always_comb begin
    for (int i = 0; i < NFLD; i++) begin
      fld_d[i] = fld_val[i];
      any_d[i] = fld_any[i];
      if (wr && (addr == REG_AW'(i))) begin
        fld_d[i] = wdata[FW_MAX-1:0] & low_ones(FW[i])[FW_MAX-1:0];
        any_d[i] = wdata[DW-1];
      end
    end
    mask_d  = mask;
    sect_d  = section;
    typ_d   = typ;
    armed_d = armed;
    if (wr && (addr == A_MASK)) mask_d = wdata[SEC_W-1:0];
    if (wr && (addr == A_SECT)) sect_d = wdata[1:0];
    if (wr && (addr == A_TYPE)) typ_d  = wdata[2:0];
    if (en_wr)                              armed_d = |wdata;
    else if (fire && !typ[T_REPEAT])        armed_d = 1'b0;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NFLD; i++) fld_val[i] <= '0;
      fld_any <= '1;
      mask    <= '0;
      section <= '0;
      typ     <= '0;
      armed   <= 1'b0;
    end else begin
      for (int i = 0; i < NFLD; i++) fld_val[i] <= fld_d[i];
      fld_any <= any_d;
      mask    <= mask_d;
      section <= sect_d;
      typ     <= typ_d;
      armed   <= armed_d;
    end
  end

  // readback
  always_comb begin
    rdata = '0;
    for (int i = 0; i < NFLD; i++) begin
      if (addr == REG_AW'(i)) begin
        rdata[FW_MAX-1:0] = fld_val[i];
        rdata[DW-1]       = fld_any[i];
      end
    end
    case (addr)
      A_MASK:  rdata[SEC_W-1:0] = mask;
      A_SECT:  rdata[1:0]       = section;
      A_TYPE:  rdata[2:0]       = typ;
      A_EN:    rdata[0]         = armed;
      default: ;
    endcase
  end
endmodule

// File: rtl/inj_match.sv
module inj_match
  import inj_pkg::*;
#(
  parameter int FW_MAX = 16
) (
  input  logic [FW_MAX-1:0] acc_fld [NFLD],
  input  logic [FW_MAX-1:0] fld_val [NFLD],
  input  logic [NFLD-1:0]   fld_any,
  output logic              match_all
);
  logic [NFLD-1:0] eq;

  for (genvar i = 0; i < NFLD; i++) begin : g_fld
    assign eq[i] = fld_any[i] || (acc_fld[i] == fld_val[i]);
  end

  assign match_all = &eq;
endmodule

// File: rtl/inj_corrupt.sv
module inj_corrupt
  import inj_pkg::*;
#(
  parameter int SEC_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  acc_valid,
  input  logic                  acc_write,
  input  logic [NSEC*SEC_W-1:0] acc_chk,
  input  logic [NSEC-1:0]       acc_par,
  input  logic                  match_all,
  input  logic                  armed,
  input  logic [SEC_W-1:0]      mask,
  input  logic [NSEC-1:0]       section,
  input  logic [2:0]            typ,
  output logic                  fire,
  output logic                  out_valid,
  output logic [NSEC*SEC_W-1:0] out_chk,
  output logic [NSEC-1:0]       out_par,
  output logic                  out_inj
);
  logic [NSEC*SEC_W-1:0] chk_flip;
  logic [NSEC-1:0]       par_flip;
  logic                  has_effect;
  logic                  vld_d, inj_d;
  logic [NSEC*SEC_W-1:0] chk_d;
  logic [NSEC-1:0]       par_d;

  assign has_effect = (typ[T_ECC] || typ[T_PAR]) && (|section);
  assign fire = acc_valid && acc_write && armed && match_all && has_effect;

  for (genvar s = 0; s < NSEC; s++) begin : g_sec
    assign chk_flip[s*SEC_W +: SEC_W] = (section[s] && typ[T_ECC]) ? mask : '0;
    assign par_flip[s]                = section[s] && typ[T_PAR];
  end

  // next state
  always_comb begin
    vld_d = acc_valid;
    inj_d = fire;
    chk_d = fire ? (acc_chk ^ chk_flip) : acc_chk;
    par_d = fire ? (acc_par ^ par_flip) : acc_par;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_inj   <= 1'b0;
      out_chk   <= '0;
      out_par   <= '0;
    end else begin
      out_valid <= vld_d;
      out_inj   <= inj_d;
      out_chk   <= chk_d;
      out_par   <= par_d;
    end
  end
endmodule

// File: rtl/mem_err_injector.sv
module mem_err_injector
  import inj_pkg::*;
#(
  parameter int MOD_W  = 2,
  parameter int RANK_W = 2,
  parameter int CH_W   = 2,
  parameter int BANK_W = 3,
  parameter int PAGE_W = 16,
  parameter int COL_W  = 10,
  parameter int SEC_W  = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_wr,
  input  logic [REG_AW-1:0]     reg_addr,
  input  logic [DW-1:0]         reg_wdata,
  output logic [DW-1:0]         reg_rdata,
  input  logic                  acc_valid,
  input  logic                  acc_write,
  input  logic [MOD_W-1:0]      acc_mod,
  input  logic [RANK_W-1:0]     acc_rank,
  input  logic [CH_W-1:0]       acc_chan,
  input  logic [BANK_W-1:0]     acc_bank,
  input  logic [PAGE_W-1:0]     acc_page,
  input  logic [COL_W-1:0]      acc_col,
  input  logic [NSEC*SEC_W-1:0] acc_chk,
  input  logic [NSEC-1:0]       acc_par,
  output logic                  out_valid,
  output logic [NSEC*SEC_W-1:0] out_chk,
  output logic [NSEC-1:0]       out_par,
  output logic                  out_inj
);
  localparam int FW_MAX = fw_max(MOD_W, RANK_W, CH_W, BANK_W, PAGE_W, COL_W);

  logic [1:0]        rst_sync;
  logic              rst_int_n;
  logic [FW_MAX-1:0] acc_fld [NFLD];
  logic [FW_MAX-1:0] fld_val [NFLD];
  logic [NFLD-1:0]   fld_any;
  logic [SEC_W-1:0]  mask_q;
  logic [1:0]        sect_q;
  logic [2:0]        typ_q;
  logic              armed_q;
  logic              match_all;
  logic              fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  assign acc_fld[0] = FW_MAX'(acc_mod);
  assign acc_fld[1] = FW_MAX'(acc_rank);
  assign acc_fld[2] = FW_MAX'(acc_chan);
  assign acc_fld[3] = FW_MAX'(acc_bank);
  assign acc_fld[4] = FW_MAX'(acc_page);
  assign acc_fld[5] = FW_MAX'(acc_col);

  inj_regs #(
    .MOD_W(MOD_W), .RANK_W(RANK_W), .CH_W(CH_W), .BANK_W(BANK_W),
    .PAGE_W(PAGE_W), .COL_W(COL_W), .SEC_W(SEC_W), .FW_MAX(FW_MAX)
  ) u_regs (
    .clk(clk), .rst_n(rst_int_n), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .fire(fire),
    .fld_val(fld_val), .fld_any(fld_any), .mask(mask_q),
    .section(sect_q), .typ(typ_q), .armed(armed_q)
  );

  inj_match #(.FW_MAX(FW_MAX)) u_match (
    .acc_fld(acc_fld), .fld_val(fld_val), .fld_any(fld_any),
    .match_all(match_all)
  );

  inj_corrupt #(.SEC_W(SEC_W)) u_corrupt (
    .clk(clk), .rst_n(rst_int_n), .acc_valid(acc_valid),
    .acc_write(acc_write), .acc_chk(acc_chk), .acc_par(acc_par),
    .match_all(match_all), .armed(armed_q), .mask(mask_q),
    .section(sect_q), .typ(typ_q), .fire(fire),
    .out_valid(out_valid), .out_chk(out_chk), .out_par(out_par),
    .out_inj(out_inj)
  );
endmodule

// File: rtl/inj_checker.sv
module inj_checker
  import inj_pkg::*;
#(
  parameter int SEC_W = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  reg_wr,
  input logic [REG_AW-1:0]     reg_addr,
  input logic [DW-1:0]         reg_wdata,
  input logic                  acc_valid,
  input logic                  acc_write,
  input logic [NSEC*SEC_W-1:0] acc_chk,
  input logic [NSEC-1:0]       acc_par,
  input logic                  out_valid,
  input logic [NSEC*SEC_W-1:0] out_chk,
  input logic [NSEC-1:0]       out_par,
  input logic                  out_inj,
  input logic                  armed,
  input logic [2:0]            typ,
  input logic [1:0]            section
);
  p_pass_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_inj |-> out_chk == $past(acc_chk) && out_par == $past(acc_par));

  p_inj_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_inj |-> $past(acc_valid && acc_write && armed));

  p_single_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_inj && !$past(typ[T_REPEAT]) && !$past(reg_wr && reg_addr == A_EN) |-> !armed);

  p_disarm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(reg_wr && reg_addr == A_EN && reg_wdata == '0) |-> !armed);

  p_arm_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(reg_wr && reg_addr == A_EN && reg_wdata != '0) |-> armed);

  p_low_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_inj && $past(section) == 2'b01 |->
      out_chk[2*SEC_W-1:SEC_W] == $past(acc_chk[2*SEC_W-1:SEC_W]) && out_par[1] == $past(acc_par[1]));

  p_par_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_inj && !$past(typ[T_ECC]) |-> out_chk == $past(acc_chk));

  p_noeffect_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_inj |-> $past(typ[T_ECC] || typ[T_PAR]));
endmodule

bind mem_err_injector inj_checker #(.SEC_W(SEC_W)) u_chk (
  .clk(clk), .rst_n(rst_int_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .acc_valid(acc_valid), .acc_write(acc_write),
  .acc_chk(acc_chk), .acc_par(acc_par), .out_valid(out_valid),
  .out_chk(out_chk), .out_par(out_par), .out_inj(out_inj),
  .armed(armed_q), .typ(typ_q), .section(sect_q)
);

// File: tb/mem_err_injector_bench.sv
`timescale 1ns/1ps
module mem_err_injector_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        acc_valid, acc_write;
  logic [1:0]  acc_mod, acc_rank, acc_chan;
  logic [2:0]  acc_bank;
  logic [15:0] acc_page;
  logic [9:0]  acc_col;
  logic [15:0] acc_chk;
  logic [1:0]  acc_par;
  logic        out_valid;
  logic [15:0] out_chk;
  logic [1:0]  out_par;
  logic        out_inj;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  mem_err_injector u_mem_err_injector (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_valid(acc_valid),
    .acc_write(acc_write), .acc_mod(acc_mod), .acc_rank(acc_rank),
    .acc_chan(acc_chan), .acc_bank(acc_bank), .acc_page(acc_page),
    .acc_col(acc_col), .acc_chk(acc_chk), .acc_par(acc_par),
    .out_valid(out_valid), .out_chk(out_chk), .out_par(out_par),
    .out_inj(out_inj)
  );

  // {mod,rank,chan,bank,page,col,wr,chk,par,exp_chk,exp_par,exp_inj}
  localparam int VW = 73;
  localparam int NV = 8;
  localparam logic [VW-1:0] VEC [NV] = '{
    {2'd1, 2'd3, 2'd2, 3'd5, 16'h1234, 10'h3F0, 1'b1, 16'hA5A5, 2'b00, 16'hE5E5, 2'b11, 1'b1},
    {2'd2, 2'd3, 2'd2, 3'd5, 16'h1234, 10'h3F0, 1'b1, 16'hA5A5, 2'b00, 16'hA5A5, 2'b00, 1'b0},
    {2'd1, 2'd3, 2'd1, 3'd5, 16'h1234, 10'h3F0, 1'b1, 16'hA5A5, 2'b00, 16'hA5A5, 2'b00, 1'b0},
    {2'd1, 2'd3, 2'd2, 3'd4, 16'h1234, 10'h3F0, 1'b1, 16'hA5A5, 2'b00, 16'hA5A5, 2'b00, 1'b0},
    {2'd1, 2'd3, 2'd2, 3'd5, 16'h1234, 10'h3F1, 1'b1, 16'hA5A5, 2'b00, 16'hA5A5, 2'b00, 1'b0},
    {2'd1, 2'd3, 2'd2, 3'd5, 16'h1234, 10'h3F0, 1'b0, 16'h5A5A, 2'b01, 16'h5A5A, 2'b01, 1'b0},
    {2'd1, 2'd0, 2'd2, 3'd5, 16'hFFFF, 10'h3F0, 1'b1, 16'h0000, 2'b10, 16'h4040, 2'b01, 1'b1},
    {2'd1, 2'd1, 2'd2, 3'd5, 16'h0000, 10'h3F0, 1'b1, 16'hFFFF, 2'b01, 16'hBFBF, 2'b10, 1'b1}
  };
  localparam string VTAG [NV] = '{"R5 R8", "R3", "R3", "R3", "R3", "R10", "R4", "R4 R8"};

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic access(input logic [1:0] m, input logic [1:0] r, input logic [1:0] c,
                        input logic [2:0] b, input logic [15:0] p, input logic [9:0] co,
                        input logic w, input logic [15:0] k, input logic [1:0] pa);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = w; acc_mod = m; acc_rank = r; acc_chan = c;
    acc_bank = b; acc_page = p; acc_col = co; acc_chk = k; acc_par = pa;
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic hit(input logic [15:0] k, input logic [1:0] pa);
    access(2'd1, 2'd0, 2'd2, 3'd5, 16'h0042, 10'h3F0, 1'b1, k, pa);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    acc_valid = 1'b0; acc_write = 1'b0; acc_mod = '0; acc_rank = '0;
    acc_chan = '0; acc_bank = '0; acc_page = '0; acc_col = '0;
    acc_chk = '0; acc_par = '0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1 reset state
    for (int i = 0; i < 6; i++) begin
      rd(4'(i), d);
      check("R1 field reset", d, 32'h8000_0000);
    end
    for (int i = 6; i < 10; i++) begin
      rd(4'(i), d);
      check("R1 ctrl reset", d, 32'h0);
    end
    check("R1 out_valid reset", {31'b0, out_valid}, 32'h0);

    // Repeat configuration for table
    wr(4'h0, 32'h1);
    wr(4'h2, 32'h2);
    wr(4'h3, 32'h5);
    wr(4'h5, 32'h3F0);
    wr(4'h6, 32'h40);
    wr(4'h7, 32'h3);
    wr(4'h8, 32'h7);
    wr(4'h9, 32'h1);

    // R2 readback
    rd(4'h5, d); check("R2 column readback", d, 32'h0000_03F0);
    rd(4'h1, d); check("R2 rank wildcard kept", d, 32'h8000_0000);
    rd(4'h6, d); check("R2 mask readback", d, 32'h40);
    rd(4'h8, d); check("R2 type readback", d, 32'h7);
    rd(4'h9, d); check("R2 enable readback", d, 32'h1);

    for (int v = 0; v < NV; v++) begin
      logic [VW-1:0] e;
      e = VEC[v];
      access(e[72:71], e[70:69], e[68:67], e[66:64], e[63:48], e[47:38],
             e[37], e[36:21], e[20:19]);
      check({VTAG[v], " chk"}, {16'b0, out_chk}, {16'b0, e[18:3]});
      check({VTAG[v], " par"}, {30'b0, out_par}, {30'b0, e[2:1]});
      check({VTAG[v], " inj"}, {31'b0, out_inj}, {31'b0, e[0]});
      check({VTAG[v], " valid"}, {31'b0, out_valid}, 32'h1);
    end

    // R8 still armed, then disarm
    rd(4'h9, d); check("R8 armed after repeats", d, 32'h1);
    wr(4'h9, 32'h0);
    rd(4'h9, d); check("R8 disarmed", d, 32'h0);
    hit(16'h1234, 2'b00);
    check("R8 after disarm chk", {16'b0, out_chk}, 32'h1234);
    check("R10 disarmed inj", {31'b0, out_inj}, 32'h0);

    // R7 single shot, ECC only, low section
    wr(4'h8, 32'h2);
    wr(4'h7, 32'h1);
    wr(4'h9, 32'h1);
    hit(16'h1111, 2'b00);
    check("R7 R5 low flip", {16'b0, out_chk}, 32'h1151);
    check("R7 first inj", {31'b0, out_inj}, 32'h1);
    rd(4'h9, d); check("R7 self clear", d, 32'h0);
    hit(16'h1111, 2'b00);
    check("R7 second clean", {16'b0, out_chk}, 32'h1111);
    check("R7 second inj", {31'b0, out_inj}, 32'h0);

    // R6 parity only, high section
    wr(4'h8, 32'h4);
    wr(4'h7, 32'h2);
    wr(4'h9, 32'h1);
    hit(16'h2222, 2'b00);
    check("R6 chk unchanged", {16'b0, out_chk}, 32'h2222);
    check("R6 high par", {30'b0, out_par}, 32'h2);

    // R9 type with no effect
    wr(4'h8, 32'h1);
    wr(4'h7, 32'h3);
    wr(4'h9, 32'h1);
    hit(16'h5555, 2'b01);
    check("R9 chk", {16'b0, out_chk}, 32'h5555);
    check("R9 par", {30'b0, out_par}, 32'h1);
    check("R9 inj", {31'b0, out_inj}, 32'h0);
    rd(4'h9, d); check("R9 still armed", d, 32'h1);

    // R11 arbitrary nonzero enable, high section ECC
    wr(4'h9, 32'h0);
    wr(4'h8, 32'h2);
    wr(4'h7, 32'h2);
    wr(4'h9, 32'h4);
    rd(4'h9, d); check("R11 armed by 0x4", d, 32'h1);
    hit(16'h3333, 2'b00);
    check("R11 R5 high flip", {16'b0, out_chk}, 32'h7333);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule